// File: doc/BRIEF.md
# Time-Shared Symmetric FIR Filter

This block is a fixed-point symmetric FIR filter that spends one multiplier on all of its coefficient products. It runs on a fast clock that has four clock cycles for every input sample. A base-rate strobe marks the cycle in which a new sample arrives. On that cycle the sample enters an eight-entry delay line. In each of the next four fast cycles, one mirrored tap pair is summed and multiplied by its coefficient, and the product is added into an accumulator.

The finished sum goes to the filtered output one base period after the sample was taken. A copy of the oldest delay-line entry is registered on the same edge and given the same extra latency, so the two outputs always belong together. A one-cycle valid pulse marks each update.

The coefficients are fixed signed constants set through a parameter. The accumulator is sized so that no combination of inputs and coefficients can overflow it.

Top module: `sfir_shared_mult`

## Requirements
- R1: The delay line advances only in a cycle with `sample_en` high. At that edge tap 0 takes `sample_in` and every tap k takes the old value of tap k-1. The value on `sample_in` in any other cycle has no effect on either output.
- R2: For the sample x[n] captured at a strobe, `filt_out` equals the exact two's-complement sum over i = 0..3 of c_i·(x[n-i] + x[n-7+i]). This holds for all input and coefficient extremes, with no wrap.
- R3: `filt_out` updates on the fourth rising edge after the edge that captured the strobe. `out_valid` is high for exactly the one cycle after that edge and low in every other cycle.
- R4: `dly_out` updates on the same edge as `filt_out` and carries x[n-7], the contents of tap 7 right after the shift of x[n].
- R5: Between two valid pulses, `filt_out` and `dly_out` hold their values.
- R6: With strobes exactly four cycles apart, the last product of one sample and the shift of the next sample fall on the same edge. The result committed on that edge uses the taps from before the shift.
- R7: While `rst_n` is low at a rising edge, the delay line, accumulator and both outputs clear to zero and `out_valid` goes low. After reset, the outputs are computed from a zero-filled delay line.
- R8: Coefficient i is the two's-complement field `COEFS[CW*i +: CW]`. It multiplies the pre-added sum of taps i and NTAP-1-i.
- R9: Strobes must be at least four cycles apart. Any larger gap gives the same results and the same four-edge latency. The multiplier sits idle after its fourth product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four cycles per sample period |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | Base-rate strobe; captures `sample_in` |
| sample_in | input | DW (8) | Signed input sample |
| filt_out | output | AW (19) | Signed filtered result |
| dly_out | output | DW (8) | Oldest delay-line entry, latency-matched to `filt_out` |
| out_valid | output | 1 | One-cycle pulse when both outputs update |

## Verification
With strobes spaced exactly four cycles apart, the fourth accumulation of one sample and the delay-line shift of the next sample land on the same clock edge. The bench provokes this with a back-to-back sweep of all 256 input codes, and also with extreme values alternating every period. An arithmetic model in the bench predicts each result from the pre-shift history, so any mixing of new and old taps shows up as a miscompare on `filt_out` or `dly_out`. Random gaps between strobes, with junk driven on `sample_in` in the idle cycles, show that the overlap case and the idle case give the same results.

// File: rtl/sfir_pkg.sv
// Shared width helpers for the time-shared symmetric FIR.
// Assumes signed two's-complement samples and coefficients.
package sfir_pkg;

    // Width of one pre-added pair times one coefficient
    function automatic int prod_width(int dw, int cw);
        return dw + 1 + cw;
    endfunction

    // Accumulator width: product width plus growth for npair additions
    function automatic int acc_width(int dw, int cw, int npair);
        return dw + 1 + cw + $clog2(npair);
    endfunction

endpackage

// File: rtl/sfir_slot_seq.sv
// Slot sequencer: after each strobe it walks slots 0..NPAIR-1, one per clock,
// then idles. A strobe on the last slot restarts the walk with no gap.
// Assumes strobes are at least NPAIR cycles apart.
module sfir_slot_seq #(
    parameter int NPAIR = 4,
    localparam int SW = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [SW-1:0] slot,
    output logic          busy,
    output logic          first,
    output logic          last
);

    localparam logic [SW-1:0] LAST_SLOT = SW'(NPAIR - 1);

    // Slot counter and busy flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            slot <= '0;
        end else if (start) begin
            busy <= 1'b1;
            slot <= '0;
        end else if (busy) begin
            if (slot == LAST_SLOT) busy <= 1'b0;
            else                   slot <= slot + 1'b1;
        end
    end

    assign first = busy && (slot == '0);
    assign last  = busy && (slot == LAST_SLOT);

endmodule

// File: rtl/sfir_tapline.sv
// Sample delay line with mirrored pair pre-adders.
// Shifts only when shift_en is high. Pair g is tap g plus tap NTAP-1-g.
// The pair chosen by slot is driven out, and so is the oldest tap.
module sfir_tapline #(
    parameter int DW   = 8,
    parameter int NTAP = 8,
    localparam int NPAIR = NTAP / 2,
    localparam int SW    = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic signed [DW-1:0] din,
    input  logic [SW-1:0]        slot,
    output logic signed [DW:0]   pair_sum,
    output logic signed [DW-1:0] oldest
);

    logic signed [DW-1:0] tap  [NTAP];
    logic signed [DW:0]   psum [NPAIR];

    // Delay line: tap 0 is newest, moves only on the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NTAP; k++) tap[k] <= '0;
        end else if (shift_en) begin
            tap[0] <= din;
            for (int k = 1; k < NTAP; k++) tap[k] <= tap[k-1];
        end
    end

    // One pre-adder per mirrored pair
    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        assign psum[g] = {tap[g][DW-1], tap[g]} +
                         {tap[NTAP-1-g][DW-1], tap[NTAP-1-g]};
    end

    assign pair_sum = psum[slot];
    assign oldest   = tap[NTAP-1];

endmodule

// File: rtl/sfir_mac.sv
// Shared multiply-accumulate: one multiplier, coefficient picked by slot.
// The accumulator restarts on the first slot. On the last slot the completed
// sum goes straight to the output register and a valid pulse follows.
module sfir_mac #(
    parameter int DW    = 8,
    parameter int CW    = 8,
    parameter int NPAIR = 4,
    parameter logic [NPAIR*CW-1:0] COEFS = '0,
    localparam int SW = (NPAIR > 1) ? $clog2(NPAIR) : 1,
    localparam int PW = sfir_pkg::prod_width(DW, CW),
    localparam int AW = sfir_pkg::acc_width(DW, CW, NPAIR)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SW-1:0]        slot,
    input  logic signed [DW:0]   pre,
    input  logic                 clr,
    input  logic                 en,
    input  logic                 commit,
    output logic signed [AW-1:0] y,
    output logic                 y_valid
);

    logic signed [CW-1:0] coef_tab [NPAIR];
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] acc, acc_nxt;

    // Coefficient table decoded from the packed parameter
    for (genvar g = 0; g < NPAIR; g++) begin : g_coef
        assign coef_tab[g] = COEFS[g*CW +: CW];
    end

    // The single multiplier and the accumulate adder
    assign prod    = PW'(pre) * PW'(coef_tab[slot]);
    assign acc_nxt = clr ? AW'(prod) : acc + AW'(prod);

    // Running sum, active only while slots are walking
    always_ff @(posedge clk) begin
        if (!rst_n)  acc <= '0;
        else if (en) acc <= acc_nxt;
    end

    // Result register and valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y       <= '0;
            y_valid <= 1'b0;
        end else begin
            y_valid <= commit;
            if (commit) y <= acc_nxt;
        end
    end

endmodule

// File: rtl/sfir_shared_mult.sv
// Symmetric FIR with a single shared multiplier running four times faster
// than the sample rate. The delayed-input path is balanced with one register
// that loads on the same edge as the filtered result.
// Assumes sample_en pulses at most once every NTAP/2 cycles.
module sfir_shared_mult #(
    parameter int DW   = 8,
    parameter int CW   = 8,
    parameter int NTAP = 8,
    parameter logic [(NTAP/2)*CW-1:0] COEFS = 32'h807F_ED05,
    localparam int NPAIR = NTAP / 2,
    localparam int SW    = (NPAIR > 1) ? $clog2(NPAIR) : 1,
    localparam int AW    = sfir_pkg::acc_width(DW, CW, NPAIR)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_en,
    input  logic signed [DW-1:0] sample_in,
    output logic signed [AW-1:0] filt_out,
    output logic signed [DW-1:0] dly_out,
    output logic                 out_valid
);

    logic [SW-1:0]        slot;
    logic                 busy, first, last;
    logic signed [DW:0]   pair_sum;
    logic signed [DW-1:0] oldest;

    sfir_slot_seq #(.NPAIR(NPAIR)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sample_en),
        .slot  (slot),
        .busy  (busy),
        .first (first),
        .last  (last)
    );

    sfir_tapline #(.DW(DW), .NTAP(NTAP)) u_taps (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sample_en),
        .din      (sample_in),
        .slot     (slot),
        .pair_sum (pair_sum),
        .oldest   (oldest)
    );

    sfir_mac #(.DW(DW), .CW(CW), .NPAIR(NPAIR), .COEFS(COEFS)) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot    (slot),
        .pre     (pair_sum),
        .clr     (first),
        .en      (busy),
        .commit  (last),
        .y       (filt_out),
        .y_valid (out_valid)
    );

    // Delay balance: oldest tap captured together with the filtered result
    always_ff @(posedge clk) begin
        if (!rst_n)    dly_out <= '0;
        else if (last) dly_out <= oldest;
    end

endmodule

// File: rtl/sfir_shared_mult_chk.sv
// Property checker for sfir_shared_mult, attached with bind.
// Uses its own counters to track strobe spacing and expected valid timing.
module sfir_shared_mult_chk #(
    parameter int NPAIR = 4,
    parameter int DW    = 8,
    parameter int AW    = 19,
    localparam int CNW  = $clog2(NPAIR + 1) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sample_en,
    input logic [AW-1:0] filt_out,
    input logic [DW-1:0] dly_out,
    input logic          out_valid
);

    localparam logic [CNW-1:0] NP = CNW'(NPAIR);

    logic [CNW-1:0] gap, age;
    logic           live, exp_v;

    // Cycles since the last strobe, saturating at NPAIR
    always_ff @(posedge clk) begin
        if (!rst_n)         gap <= NP;
        else if (sample_en) gap <= CNW'(1);
        else if (gap < NP)  gap <= gap + 1'b1;
    end

    // Expected valid: NPAIR edges after each captured strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live  <= 1'b0;
            age   <= '0;
            exp_v <= 1'b0;
        end else begin
            exp_v <= live && (age == NP);
            if (sample_en) begin
                live <= 1'b1;
                age  <= CNW'(1);
            end else if (live) begin
                if (age == NP) live <= 1'b0;
                else           age  <= age + 1'b1;
            end
        end
    end

    assert_strobe_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> (gap >= NP));

    assert_valid_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == exp_v);

    assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_outputs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(filt_out) && $stable(dly_out)));

    assert_reset_clears_R7: assert property (@(posedge clk)
        !rst_n |=> (filt_out == '0 && dly_out == '0 && !out_valid));

endmodule

bind sfir_shared_mult sfir_shared_mult_chk #(.NPAIR(NPAIR), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .filt_out  (filt_out),
    .dly_out   (dly_out),
    .out_valid (out_valid)
);

// File: tb/tb_sfir_shared_mult.sv
// Self-checking bench: arithmetic reference of the symmetric FIR, per-cycle
// monitor of valid timing, output values and hold behaviour.
module tb_sfir_shared_mult;

    localparam int DW = 8;
    localparam int CW = 8;
    localparam int NTAP = 8;
    localparam int AW = 19;
    localparam int C0 = 5, C1 = -19, C2 = 127, C3 = -128;
    localparam logic [31:0] COEFS = {8'(C3), 8'(C2), 8'(C1), 8'(C0)};

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 sample_en;
    logic signed [DW-1:0] sample_in;
    logic signed [AW-1:0] filt_out;
    logic signed [DW-1:0] dly_out;
    logic                 out_valid;

    sfir_shared_mult #(.DW(DW), .CW(CW), .NTAP(NTAP), .COEFS(COEFS)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .sample_in (sample_in),
        .filt_out  (filt_out),
        .dly_out   (dly_out),
        .out_valid (out_valid)
    );

    always #4 clk = ~clk;

    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    int    cf [4] = '{C0, C1, C2, C3};
    int    rt [8];
    int    q_due [$];
    int    q_y [$];
    int    q_d [$];
    string ptag = "R7";
    longint pf = 0, pd = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Capture one sample, model it, then idle gap-1 cycles with junk input
    task automatic send(int v, int gap);
        int y;
        @(negedge clk);
        sample_en = 1'b1;
        sample_in = 8'(v);
        for (int i = 7; i > 0; i--) rt[i] = rt[i-1];
        rt[0] = v;
        y = 0;
        for (int i = 0; i < 4; i++) y += cf[i] * (rt[i] + rt[7-i]);
        q_due.push_back(cyc + 5);
        q_y.push_back(y);
        q_d.push_back(rt[7]);
        for (int k = 1; k < gap; k++) begin
            @(negedge clk);
            sample_en = 1'b0;
            sample_in = 8'($urandom);
        end
    endtask

    // Monitor: R3 timing, R2/R8/R6/R9 values, R4 delayed copy, R5 hold
    always @(negedge clk) begin
        if (!rst_n) begin
            pf = 0;
            pd = 0;
        end else if (q_due.size() > 0 && q_due[0] == cyc) begin
            chk("R3 out_valid at result", longint'(out_valid), 1);
            chk({ptag, "/R2 filt_out"}, longint'(filt_out), longint'(q_y[0]));
            chk("R4/R1 dly_out", longint'(dly_out), longint'(q_d[0]));
            pf = filt_out;
            pd = dly_out;
            void'(q_due.pop_front());
            void'(q_y.pop_front());
            void'(q_d.pop_front());
        end else begin
            chk("R3 out_valid idle", longint'(out_valid), 0);
            chk("R5 filt_out hold", longint'(filt_out), pf);
            chk("R5 dly_out hold", longint'(dly_out), pd);
        end
    end

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R3 watchdog expired act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        sample_en = 1'b0;
        sample_in = '0;
        for (int i = 0; i < 8; i++) rt[i] = 0;
        repeat (3) @(negedge clk);
        chk("R7 reset filt_out", longint'(filt_out), 0);
        chk("R7 reset dly_out", longint'(dly_out), 0);
        chk("R7 reset out_valid", longint'(out_valid), 0);
        rst_n = 1'b1;

        // R8: impulse response exposes each coefficient and its tap pairing
        ptag = "R8";
        send(1, 4);
        repeat (10) send(0, 4);

        // R2: extreme magnitudes, no wrap
        ptag = "R2";
        repeat (10) send(-128, 4);
        repeat (10) send(127, 4);
        for (int i = 0; i < 16; i++) send((i % 2) ? 127 : -128, 4);

        // R9: random values with gaps of 4..8 cycles
        ptag = "R9";
        for (int i = 0; i < 150; i++) send(int'($urandom_range(255)) - 128, 4 + (i % 5));

        // R6: all codes back to back, shift and last product on one edge
        ptag = "R6";
        for (int i = 0; i < 256; i++) send(i - 128, 4);
        repeat (10) @(negedge clk);

        // R7: reset with a full delay line, then confirm it starts clean
        rst_n = 1'b0;
        @(negedge clk);
        chk("R7 mid reset filt_out", longint'(filt_out), 0);
        chk("R7 mid reset dly_out", longint'(dly_out), 0);
        chk("R7 mid reset out_valid", longint'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) rt[i] = 0;
        ptag = "R7";
        send(3, 4);
        repeat (9) send(-2, 4);
        repeat (12) @(negedge clk);

        chk("R3 results outstanding", longint'(q_due.size()), 0);
        summary();
        $finish;
    end

endmodule